// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Sign-Extension Word

This block multiplies two signed 16-bit operands and adds the product to a 32-bit signed accumulator. The accumulator is visible as a low result word and a high result word. Software writes the first operand through one strobe. Writing the second operand through another strobe starts the operation. One clock later the updated result appears, together with a 16-bit sign-extension word and a carry flag, and a one-cycle valid pulse marks that cycle.

The unit never saturates and never raises an overflow flag. When a 32-bit signed sum leaves its range, the result simply wraps. The extension word then shows the sign of the wrapped result, while the carry shows the sign of the true sum. Software detects a wrapped sum by comparing the two. A clear input zeroes the accumulator state so that a new sequence can start. A load input presets the accumulator to a chosen value.

Top module: `smac_unit`

## Requirements
- R1: After reset the result words, the extension word, the carry and the valid pulse are all zero.
- R2: When b_wr is high and neither acc_clr nor acc_load is high at a rising edge, the accumulator becomes (old accumulator + signed operand_a × signed b_data) modulo 2^32. res_valid is high for exactly the one cycle after that edge and low in every other cycle.
- R3: sum_ext is 0xFFFF when bit 31 of the accumulator is 1, and 0x0000 otherwise.
- R4: After an accumulate, carry equals bit 32 of the 33-bit sum of the sign-extended old accumulator and the sign-extended 32-bit product.
- R5: Adding a positive product to a positive accumulator so that the sum passes 0x7FFFFFFF wraps into the negative range without saturating, and leaves sum_ext = 0xFFFF with carry = 0.
- R6: Adding a negative product to a negative accumulator so that the sum falls below 0x80000000 wraps into the positive range, and leaves sum_ext = 0x0000 with carry = 1.
- R7: An accumulate whose true sum lies inside the 32-bit signed range leaves carry equal to bit 0 of sum_ext. This always holds when the old accumulator and the product have opposite signs.
- R8: acc_clr zeroes the accumulator, sum_ext and carry at the next edge. It takes priority over acc_load and b_wr, and it produces no valid pulse.
- R9: acc_load without acc_clr sets the accumulator to load_data, sets sum_ext from bit 31 of load_data, and sets carry to 0. It takes priority over b_wr and produces no valid pulse.
- R10: a_wr stores a_data as operand A, and the stored value serves every later accumulate until the next a_wr. If a_wr and b_wr are high at the same edge, the new a_data is used. a_wr alone changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr | input | 1 | Write strobe for operand A |
| a_data | input | 16 | Operand A, signed |
| b_wr | input | 1 | Write strobe for operand B; starts an accumulate |
| b_data | input | 16 | Operand B, signed |
| acc_clr | input | 1 | Clear the accumulator, extension word and carry |
| acc_load | input | 1 | Preset the accumulator from load_data |
| load_data | input | 32 | Preset value |
| res_lo | output | 16 | Accumulator bits 15:0 |
| res_hi | output | 16 | Accumulator bits 31:16 |
| sum_ext | output | 16 | Sign-extension word of the accumulator |
| carry | output | 1 | Carry out of the last 33-bit accumulation |
| res_valid | output | 1 | High for one cycle after an accumulate |

## Verification
The hardest states to reach are a wrapped sum, because no single product exceeds 2^30 in magnitude. For positive overflow, the bench accumulates the largest positive product (−32768 × −32768) twice from zero. For negative underflow, it first loads the accumulator with 0x80000000 and then adds the most negative product, −32768 × 32767. In-range mixed-sign sums come from a preset near the positive limit plus a small negative product. A long pseudo-random run, biased toward extreme operands and mixed with clears and loads, is checked cycle by cycle against a 64-bit reference sum.

// File: rtl/smac_pkg.sv
package smac_pkg;
   typedef enum logic [1:0] {
      ACC_HOLD  = 2'd0,
      ACC_CLEAR = 2'd1,
      ACC_LOAD  = 2'd2,
      ACC_ADD   = 2'd3
   } acc_op_e;
endpackage

// File: rtl/smac_product.sv
module smac_product #(
   parameter int OP_W       = 16,
   parameter int PROD_STYLE = 0,
   parameter int PW         = 2 * OP_W
) (
   input  logic [OP_W-1:0] a_i,
   input  logic [OP_W-1:0] b_i,
   output logic [PW-1:0]   prod_o
);
   generate
      if (PW != 2 * OP_W) begin : g_bad_pw
         $error("smac_product: PW must be twice OP_W");
      end
      if (PROD_STYLE == 0) begin : g_direct
         logic signed [PW-1:0] full_w;
         assign full_w = PW'($signed(a_i)) * PW'($signed(b_i));
         assign prod_o = full_w;
      end else begin : g_shift_add
         // sign-extend both to PW bits; product modulo 2^PW is the signed product
         logic [PW-1:0] a_ext;
         logic [PW-1:0] b_ext;
         logic [PW-1:0] part [PW+1];
         assign a_ext = {{(PW-OP_W){a_i[OP_W-1]}}, a_i};
         assign b_ext = {{(PW-OP_W){b_i[OP_W-1]}}, b_i};
         assign part[0] = '0;
         for (genvar i = 0; i < PW; i++) begin : g_row
            assign part[i+1] = part[i] + (a_ext[i] ? (b_ext << i) : '0);
         end
         assign prod_o = part[PW];
      end
   endgenerate
endmodule

// File: rtl/smac_ctrl.sv
module smac_ctrl
   import smac_pkg::*;
#(
   parameter int OP_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            a_wr_i,
   input  logic [OP_W-1:0] a_data_i,
   input  logic            b_wr_i,
   input  logic            clr_i,
   input  logic            load_i,
   output logic [OP_W-1:0] a_eff_o,
   output acc_op_e         op_o,
   output logic            valid_o
);
   logic [OP_W-1:0] a_q;
   logic            valid_q;

   assign a_eff_o = a_wr_i ? a_data_i : a_q;

   always_comb begin
      if (clr_i)       op_o = ACC_CLEAR;
      else if (load_i) op_o = ACC_LOAD;
      else if (b_wr_i) op_o = ACC_ADD;
      else             op_o = ACC_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q     <= '0;
         valid_q <= 1'b0;
      end else begin
         if (a_wr_i) a_q <= a_data_i;
         valid_q <= (op_o == ACC_ADD);
      end
   end

   assign valid_o = valid_q;

   // R2
   valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> $past(b_wr_i && !clr_i && !load_i));

   // R10
   a_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !a_wr_i |=> a_q == $past(a_q));
endmodule

// File: rtl/smac_accum.sv
module smac_accum
   import smac_pkg::*;
#(
   parameter int ACC_W = 32,
   parameter int PW    = 32,
   parameter int EXT_W = ACC_W / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  acc_op_e          op_i,
   input  logic [PW-1:0]    prod_i,
   input  logic [ACC_W-1:0] load_i,
   output logic [ACC_W-1:0] acc_o,
   output logic [EXT_W-1:0] ext_o,
   output logic             carry_o
);
   localparam int SX_W = ACC_W + 1 - PW;

   logic [ACC_W-1:0] acc_q;
   logic [EXT_W-1:0] ext_q;
   logic             carry_q;
   logic [ACC_W:0]   sum_w;

   assign sum_w = {acc_q[ACC_W-1], acc_q} + {{SX_W{prod_i[PW-1]}}, prod_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         ext_q   <= '0;
         carry_q <= 1'b0;
      end else begin
         case (op_i)
            ACC_CLEAR: begin
               acc_q   <= '0;
               ext_q   <= '0;
               carry_q <= 1'b0;
            end
            ACC_LOAD: begin
               acc_q   <= load_i;
               ext_q   <= {EXT_W{load_i[ACC_W-1]}};
               carry_q <= 1'b0;
            end
            ACC_ADD: begin
               acc_q   <= sum_w[ACC_W-1:0];
               ext_q   <= {EXT_W{sum_w[ACC_W-1]}};
               carry_q <= sum_w[ACC_W];
            end
            default: ;
         endcase
      end
   end

   assign acc_o   = acc_q;
   assign ext_o   = ext_q;
   assign carry_o = carry_q;

   // R3
   ext_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_q == {EXT_W{acc_q[ACC_W-1]}});

   // R8
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == ACC_CLEAR |=> acc_q == '0 && ext_q == '0 && !carry_q);

   // R9
   load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == ACC_LOAD |=> acc_q == $past(load_i) && !carry_q);

   // R7
   mixed_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == ACC_ADD && acc_q[ACC_W-1] != prod_i[PW-1]) |=> carry_q == ext_q[0]);
endmodule

// File: rtl/smac_unit.sv
module smac_unit
   import smac_pkg::*;
#(
   parameter int OP_W       = 16,
   parameter int ACC_W      = 32,
   parameter int PROD_STYLE = 0,
   parameter int HALF_W     = ACC_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_wr,
   input  logic [OP_W-1:0]   a_data,
   input  logic              b_wr,
   input  logic [OP_W-1:0]   b_data,
   input  logic              acc_clr,
   input  logic              acc_load,
   input  logic [ACC_W-1:0]  load_data,
   output logic [HALF_W-1:0] res_lo,
   output logic [HALF_W-1:0] res_hi,
   output logic [HALF_W-1:0] sum_ext,
   output logic              carry,
   output logic              res_valid
);
   localparam int PW = 2 * OP_W;

   generate
      if (OP_W < 2) begin : g_bad_op
         $error("smac_unit: OP_W must be at least 2");
      end
      if (ACC_W < PW) begin : g_bad_acc
         $error("smac_unit: ACC_W must hold a full product");
      end
      if (ACC_W % 2 != 0) begin : g_bad_half
         $error("smac_unit: ACC_W must be even");
      end
      if (PROD_STYLE < 0 || PROD_STYLE > 1) begin : g_bad_style
         $error("smac_unit: PROD_STYLE must be 0 or 1");
      end
   endgenerate

   logic [OP_W-1:0]  a_eff;
   acc_op_e          op;
   logic [PW-1:0]    prod;
   logic [ACC_W-1:0] acc;

   smac_ctrl #(.OP_W(OP_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .a_wr_i   (a_wr),
      .a_data_i (a_data),
      .b_wr_i   (b_wr),
      .clr_i    (acc_clr),
      .load_i   (acc_load),
      .a_eff_o  (a_eff),
      .op_o     (op),
      .valid_o  (res_valid)
   );

   smac_product #(.OP_W(OP_W), .PROD_STYLE(PROD_STYLE), .PW(PW)) u_prod (
      .a_i    (a_eff),
      .b_i    (b_data),
      .prod_o (prod)
   );

   smac_accum #(.ACC_W(ACC_W), .PW(PW), .EXT_W(HALF_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_i    (op),
      .prod_i  (prod),
      .load_i  (load_data),
      .acc_o   (acc),
      .ext_o   (sum_ext),
      .carry_o (carry)
   );

   assign res_lo = acc[HALF_W-1:0];
   assign res_hi = acc[ACC_W-1:HALF_W];
endmodule

// File: tb/tb_smac_unit.sv
`timescale 1ns/1ps
module tb_smac_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_wr = 1'b0;
   logic [15:0] a_data = '0;
   logic        b_wr = 1'b0;
   logic [15:0] b_data = '0;
   logic        acc_clr = 1'b0;
   logic        acc_load = 1'b0;
   logic [31:0] load_data = '0;
   logic [15:0] res_lo, res_hi, sum_ext;
   logic        carry, res_valid;

   int checks = 0;
   int errors = 0;
   logic [31:0] seed = 32'h1234_5678;

   longint      ref_sum = 0;
   logic [15:0] m_a = '0;
   logic [31:0] m_acc = '0;
   logic [15:0] m_ext = '0;
   logic        m_c = 1'b0;
   logic        m_v = 1'b0;

   always #2.5 clk = ~clk;

   smac_unit dut (
      .clk(clk), .rst_n(rst_n), .a_wr(a_wr), .a_data(a_data), .b_wr(b_wr),
      .b_data(b_data), .acc_clr(acc_clr), .acc_load(acc_load),
      .load_data(load_data), .res_lo(res_lo), .res_hi(res_hi),
      .sum_ext(sum_ext), .carry(carry), .res_valid(res_valid)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model_step();
      longint p;
      longint s;
      m_v = 1'b0;
      if (a_wr) m_a = a_data;
      if (acc_clr) begin
         ref_sum = 0; m_acc = '0; m_ext = '0; m_c = 1'b0;
      end else if (acc_load) begin
         ref_sum = longint'($signed(load_data));
         m_acc = load_data; m_ext = {16{load_data[31]}}; m_c = 1'b0;
      end else if (b_wr) begin
         p = longint'($signed(m_a)) * longint'($signed(b_data));
         s = longint'($signed(m_acc)) + p;
         ref_sum = ref_sum + p;
         m_acc = ref_sum[31:0];
         m_c = s[32];
         m_ext = {16{m_acc[31]}};
         m_v = 1'b1;
      end
   endtask

   task automatic cyc(string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(tag, "res_lo", {16'h0, res_lo}, {16'h0, m_acc[15:0]});
      chk(tag, "res_hi", {16'h0, res_hi}, {16'h0, m_acc[31:16]});
      chk(tag, "sum_ext", {16'h0, sum_ext}, {16'h0, m_ext});
      chk(tag, "carry", {31'h0, carry}, {31'h0, m_c});
      chk(tag, "res_valid", {31'h0, res_valid}, {31'h0, m_v});
   endtask

   task automatic idle(string tag);
      a_wr = 0; b_wr = 0; acc_clr = 0; acc_load = 0;
      cyc(tag);
   endtask

   task automatic mac(logic [15:0] a, logic [15:0] b, string tag);
      a_wr = 1; a_data = a; b_wr = 1; b_data = b;
      cyc(tag);
      idle(tag);
   endtask

   task automatic only_b(logic [15:0] b, string tag);
      b_wr = 1; b_data = b;
      cyc(tag);
      idle(tag);
   endtask

   task automatic load(logic [31:0] v, string tag);
      acc_load = 1; load_data = v;
      cyc(tag);
      idle(tag);
   endtask

   task automatic clear(string tag);
      acc_clr = 1;
      cyc(tag);
      idle(tag);
   endtask

   function automatic logic [15:0] pick(logic [31:0] r);
      case (r[3:1])
         3'd0: return 16'h8000;
         3'd1: return 16'h7FFF;
         3'd2: return 16'hFFFF;
         default: return r[31:16];
      endcase
   endfunction

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 outputs are zero after reset
      chk("R1", "res_lo", {16'h0, res_lo}, 32'h0);
      chk("R1", "res_hi", {16'h0, res_hi}, 32'h0);
      chk("R1", "sum_ext", {16'h0, sum_ext}, 32'h0);
      chk("R1", "carry", {31'h0, carry}, 32'h0);
      chk("R1", "res_valid", {31'h0, res_valid}, 32'h0);
      rst_n = 1;
      idle("R1");

      // R2 basic accumulate and one-cycle valid
      mac(16'd3, 16'd4, "R2");
      // R7 mixed sign, in range: -5*7
      mac(16'hFFFB, 16'd7, "R7");
      // R10 operand A kept across B writes
      only_b(16'd2, "R10");
      // R10 a_wr alone changes nothing
      a_wr = 1; a_data = 16'h1111;
      cyc("R10");
      idle("R10");
      only_b(16'd1, "R10");

      // R8 clear beats accumulate
      acc_clr = 1; b_wr = 1; b_data = 16'd9;
      cyc("R8");
      idle("R8");

      // R5 positive overflow: 2^30 twice
      mac(16'h8000, 16'h8000, "R5");
      mac(16'h8000, 16'h8000, "R5");
      chk("R5", "wrap", {res_hi, res_lo}, 32'h8000_0000);
      chk("R5", "ext_vs_carry", {31'h0, sum_ext[0] ^ carry}, 32'h1);

      // R6 negative underflow
      load(32'h8000_0000, "R9");
      mac(16'h8000, 16'h7FFF, "R6");
      chk("R6", "sum_ext", {16'h0, sum_ext}, 32'h0);
      chk("R6", "carry", {31'h0, carry}, 32'h1);

      // R9 clear wins over load
      acc_clr = 1; acc_load = 1; load_data = 32'h1234_5678;
      cyc("R8");
      idle("R8");
      // R9 load beats accumulate
      acc_load = 1; load_data = 32'hF000_0001; b_wr = 1; b_data = 16'd5;
      cyc("R9");
      idle("R9");

      // R7 near positive limit plus small negative product
      load(32'h7FFF_FFF0, "R9");
      mac(16'hFFFF, 16'd100, "R7");
      chk("R7", "carry_eq_sign", {31'h0, carry}, {31'h0, sum_ext[0]});
      // R4 negative accumulator, positive product
      load(32'hFFFF_FF00, "R9");
      mac(16'd1, 16'd300, "R4");

      // R4 R3 pseudo-random run
      for (int i = 0; i < 3000; i++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         a_wr = seed[4]; a_data = pick(seed);
         seed = seed * 32'd1103515245 + 32'd12345;
         b_wr = seed[5] | seed[6]; b_data = pick(seed);
         acc_clr = (seed[12:8] == 5'd0);
         acc_load = (seed[12:8] == 5'd1);
         load_data = {seed[31:16], seed[15:0] ^ 16'hA5A5};
         cyc("R4");
      end
      idle("R3");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule